// File: doc/BRIEF.md
# Self-Rewriting Dataflow Node Engine

This block runs a dataflow program held as a small table of fixed-size graph nodes. Every node carries an operation, two input operand slots and two outgoing links. A link names a target node and which of its two input slots it feeds. The block has no program counter and no load or store path. A node fires as soon as its operands are present. Firing consumes the operands and pushes the produced tokens along the node's links. Besides arithmetic, pass-through and steering, two operations let the running program change its own graph. One clones a node into a slot taken from the free pool and returns a pointer to the clone. The other redirects a node's first link. A third operation returns a node to the free pool.

The host writes node records through the load port and feeds operand tokens through the injection port. It watches tokens leave through the result port. A token sent on edge 0 of a node whose link 0 is disabled goes to the result port. A token sent on an unlinked edge 1 is dropped. Each token carries a tag that marks it as plain data or as a node pointer. A pointer's value is a node index held in its low bits. At most one ready node fires per clock. A round-robin pointer over the table chooses which one. The firing effects and the result and error outputs all appear after that clock edge.

Top module: `smdgEngine`

## Requirements
- R1: After reset every node is free with both slots empty, resValid and errValid are low, and injReady is low for every slot, because only loaded nodes accept tokens.
- R2: A load writes the operation (ldOp) and both links into node ldNode, empties its slots and marks it in use. In any cycle with ldValid high, no node fires. Link encoding is {enable, node index, slot} with the slot in bit 0.
- R3: A node fires only when slot 0 is full, and slot 1 is also full for two-operand operations (ADD=0, SUB=1, STEER=3, REDIRECT=5). PASS=2, CLONE=4 and RELEASE=6 use slot 0 only. Firing empties both slots.
- R4: ADD and SUB give a data token with the sum or difference (slot0 minus slot1) modulo 2^DATA_W and send it on both edges. PASS sends the slot-0 token with its tag unchanged on both edges.
- R5: STEER sends the slot-0 token, tag unchanged, on edge 0 when the slot-1 value is nonzero and on edge 1 otherwise. The other edge gets nothing.
- R6: CLONE takes a pointer P and copies the operation and both links of node P into the lowest-numbered free node N, with N's slots empty. It emits a pointer token of value N on edge 0.
- R7: REDIRECT takes pointers A (slot 0) and B (slot 1) and overwrites link 0 of node A with an enabled link to slot 0 of node B. It emits nothing.
- R8: RELEASE takes a pointer P and returns node P to the free pool, so a later CLONE can allocate it again.
- R9: Every slot holds one token. A producer whose target slot is full does not fire until that slot drains. The held token is not lost or overwritten, and injReady stays low while the addressed slot is full.
- R10: When several nodes are ready, the first ready node at or after the round-robin pointer fires. The pointer then moves to the node after the winner. It is zero after reset.
- R11: A CLONE when no node is free pulses errValid with errCode 2. It emits nothing and leaves every node record as it was.
- R12: ADD or SUB with a pointer operand, and CLONE, RELEASE or REDIRECT with a data operand, pulse errValid with errCode 1. The operands are consumed and nothing is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Write a node record this cycle |
| ldNode | input | IDX_W | Node index to write |
| ldOp | input | 3 | Operation code |
| ldLink0 | input | IDX_W+2 | Edge-0 link {en, node, slot} |
| ldLink1 | input | IDX_W+2 | Edge-1 link {en, node, slot} |
| injValid | input | 1 | Offer an operand token |
| injNode | input | IDX_W | Target node of the offered token |
| injPort | input | 1 | Target slot of the offered token |
| injPtr | input | 1 | Tag: 1 = pointer, 0 = data |
| injData | input | DATA_W | Token value |
| injReady | output | 1 | The addressed slot accepts a token this cycle |
| resValid | output | 1 | A token left through the result port |
| resPtr | output | 1 | Tag of the emitted token |
| resData | output | DATA_W | Value of the emitted token |
| errValid | output | 1 | A firing was rejected |
| errCode | output | 2 | 1 = tag mismatch, 2 = no free node |

## Verification
A corrupted node record or operand slot shows at the result port within a few cycles of the next token that passes through that node. The result may have a wrong value or a wrong tag. A token may appear that should not, or an expected one may never come. A wrong free-pool state shows on the next CLONE, whose returned pointer is an index the bench can predict. A broken stall or arbitration rule shows as a lost operand or as results out of order. The bench sweeps operand grids and every steering case so that such faults change the observed values.

// File: rtl/smdg_pkg.sv
package smdg_pkg;
  parameter int DATA_W = 8;
  parameter int NODE_N = 8;
  localparam int IDX_W = $clog2(NODE_N);
  localparam int LINK_W = IDX_W + 2;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_PASS = 3'd2, OP_STEER = 3'd3,
    OP_CLONE = 3'd4, OP_REDIRECT = 3'd5, OP_RELEASE = 3'd6
  } op_e;

  typedef struct packed {
    logic full;
    logic isPtr;
    logic [DATA_W-1:0] val;
  } tok_t;

  typedef struct packed {
    logic en;
    logic [IDX_W-1:0] node;
    logic port;
  } link_t;

  typedef struct packed {
    logic used;
    op_e op;
    tok_t [1:0] inTok;
    link_t [1:0] link;
  } node_t;

  typedef struct packed {
    logic fire;
    logic [IDX_W-1:0] node;
    logic alu;
    logic clone;
    logic redirect;
    logic release_;
  } ctl_t;

  localparam logic [1:0] ERR_TAG = 2'd1;
  localparam logic [1:0] ERR_POOL = 2'd2;
endpackage

// File: rtl/smdgCtrl.sv
module smdgCtrl import smdg_pkg::*; (
  input  logic clk,
  input  logic rstN,
  input  logic ldValid,
  input  logic [NODE_N-1:0] readyVec,
  input  op_e opVec [NODE_N],
  output ctl_t ctl
);
  logic [IDX_W-1:0] rrPtr;

  always_comb begin
    ctl = '0;
    for (int k = 0; k < NODE_N; k++) begin
      if (!ctl.fire && readyVec[(int'(rrPtr) + k) % NODE_N]) begin
        ctl.fire = 1'b1;
        ctl.node = IDX_W'((int'(rrPtr) + k) % NODE_N);
      end
    end
    if (ldValid) ctl.fire = 1'b0;
    ctl.alu      = ctl.fire && (opVec[ctl.node] == OP_ADD || opVec[ctl.node] == OP_SUB);
    ctl.clone    = ctl.fire && opVec[ctl.node] == OP_CLONE;
    ctl.redirect = ctl.fire && opVec[ctl.node] == OP_REDIRECT;
    ctl.release_ = ctl.fire && opVec[ctl.node] == OP_RELEASE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rrPtr <= '0;
    else if (ctl.fire) rrPtr <= IDX_W'((int'(ctl.node) + 1) % NODE_N);
  end
endmodule

// File: rtl/smdgDatapath.sv
module smdgDatapath import smdg_pkg::*; (
  input  logic clk,
  input  logic rstN,
  input  ctl_t ctl,
  input  logic ldValid,
  input  logic [IDX_W-1:0] ldNode,
  input  logic [2:0] ldOp,
  input  logic [LINK_W-1:0] ldLink0,
  input  logic [LINK_W-1:0] ldLink1,
  input  logic injValid,
  input  logic [IDX_W-1:0] injNode,
  input  logic injPort,
  input  logic injPtr,
  input  logic [DATA_W-1:0] injData,
  output logic injReady,
  output logic [NODE_N-1:0] readyVec,
  output logic [NODE_N-1:0] usedVec,
  output op_e opVec [NODE_N],
  output logic resValid,
  output logic resPtr,
  output logic [DATA_W-1:0] resData,
  output logic errValid,
  output logic [1:0] errCode
);
  node_t tbl [NODE_N];
  node_t cur;
  tok_t a, b;
  tok_t [1:0] outTok;
  logic [1:0] outEn;
  logic [IDX_W-1:0] aIdx, bIdx, freeIdx;
  logic typeErr, anyFree, errNow, injHit;
  logic [DATA_W-1:0] aluVal;

  function automatic logic [1:0] emitMask(node_t n);
    case (n.op)
      OP_ADD, OP_SUB, OP_PASS: emitMask = 2'b11;
      OP_STEER: emitMask = (n.inTok[1].val != '0) ? 2'b01 : 2'b10;
      OP_CLONE: emitMask = 2'b01;
      default: emitMask = 2'b00;
    endcase
  endfunction

  // readiness: operands present and every target slot empty
  always_comb begin
    for (int i = 0; i < NODE_N; i++) begin
      logic needTwo, blocked;
      logic [1:0] em;
      needTwo = tbl[i].op inside {OP_ADD, OP_SUB, OP_STEER, OP_REDIRECT};
      em = emitMask(tbl[i]);
      blocked = 1'b0;
      for (int e = 0; e < 2; e++)
        if (em[e] && tbl[i].link[e].en &&
            tbl[tbl[i].link[e].node].inTok[tbl[i].link[e].port].full)
          blocked = 1'b1;
      readyVec[i] = tbl[i].used && tbl[i].inTok[0].full &&
                    (!needTwo || tbl[i].inTok[1].full) && !blocked;
      usedVec[i] = tbl[i].used;
      opVec[i] = tbl[i].op;
    end
  end

  // firing node evaluation
  always_comb begin
    cur = tbl[ctl.node];
    a = cur.inTok[0];
    b = cur.inTok[1];
    aIdx = a.val[IDX_W-1:0];
    bIdx = b.val[IDX_W-1:0];
    typeErr = 1'b0;
    if (ctl.alu) typeErr = a.isPtr | b.isPtr;
    if (ctl.clone | ctl.release_) typeErr = !a.isPtr;
    if (ctl.redirect) typeErr = !(a.isPtr & b.isPtr);
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = NODE_N - 1; i >= 0; i--)
      if (!tbl[i].used) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    errNow = ctl.fire && (typeErr || (ctl.clone && !anyFree));
    aluVal = (cur.op == OP_SUB) ? a.val - b.val : a.val + b.val;
    outTok[0] = a;
    outTok[1] = a;
    if (ctl.alu) begin
      outTok[0] = {1'b1, 1'b0, aluVal};
      outTok[1] = outTok[0];
    end
    if (ctl.clone) outTok[0] = {1'b1, 1'b1, DATA_W'(freeIdx)};
    outEn = (ctl.fire && !errNow) ? emitMask(cur) : 2'b00;
    injHit = 1'b0;
    for (int e = 0; e < 2; e++)
      if (outEn[e] && cur.link[e].en && cur.link[e].node == injNode &&
          cur.link[e].port == injPort)
        injHit = 1'b1;
    if (ctl.release_ && !errNow && aIdx == injNode) injHit = 1'b1;
    injReady = tbl[injNode].used && !tbl[injNode].inTok[injPort].full && !injHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NODE_N; i++) tbl[i] <= '0;
      resValid <= 1'b0;
      resPtr <= 1'b0;
      resData <= '0;
      errValid <= 1'b0;
      errCode <= '0;
    end else begin
      resValid <= 1'b0;
      errValid <= 1'b0;
      if (injValid && injReady)
        tbl[injNode].inTok[injPort] <= {1'b1, injPtr, injData};
      if (ctl.fire) begin
        tbl[ctl.node].inTok <= '0;
        if (errNow) begin
          errValid <= 1'b1;
          errCode <= typeErr ? ERR_TAG : ERR_POOL;
        end
        for (int e = 0; e < 2; e++)
          if (outEn[e]) begin
            if (cur.link[e].en)
              tbl[cur.link[e].node].inTok[cur.link[e].port] <= outTok[e];
            else if (e == 0) begin
              resValid <= 1'b1;
              resPtr <= outTok[0].isPtr;
              resData <= outTok[0].val;
            end
          end
        if (ctl.clone && !errNow) begin
          tbl[freeIdx].used <= 1'b1;
          tbl[freeIdx].op <= tbl[aIdx].op;
          tbl[freeIdx].inTok <= '0;
          tbl[freeIdx].link <= tbl[aIdx].link;
        end
        if (ctl.redirect && !errNow) tbl[aIdx].link[0] <= {1'b1, bIdx, 1'b0};
        if (ctl.release_ && !errNow) tbl[aIdx] <= '0;
      end
      if (ldValid) begin
        tbl[ldNode].used <= 1'b1;
        tbl[ldNode].op <= op_e'(ldOp);
        tbl[ldNode].inTok <= '0;
        tbl[ldNode].link[0] <= link_t'(ldLink0);
        tbl[ldNode].link[1] <= link_t'(ldLink1);
      end
    end
  end
endmodule

// File: rtl/smdgEngine.sv
module smdgEngine import smdg_pkg::*; (
  input  logic clk,
  input  logic rstN,
  input  logic ldValid,
  input  logic [IDX_W-1:0] ldNode,
  input  logic [2:0] ldOp,
  input  logic [LINK_W-1:0] ldLink0,
  input  logic [LINK_W-1:0] ldLink1,
  input  logic injValid,
  input  logic [IDX_W-1:0] injNode,
  input  logic injPort,
  input  logic injPtr,
  input  logic [DATA_W-1:0] injData,
  output logic injReady,
  output logic resValid,
  output logic resPtr,
  output logic [DATA_W-1:0] resData,
  output logic errValid,
  output logic [1:0] errCode
);
  ctl_t ctl;
  logic [NODE_N-1:0] readyVec;
  logic [NODE_N-1:0] usedVec;
  op_e opVec [NODE_N];

  smdgCtrl uCtrl (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .readyVec(readyVec),
    .opVec(opVec), .ctl(ctl)
  );

  smdgDatapath uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ldValid(ldValid), .ldNode(ldNode),
    .ldOp(ldOp), .ldLink0(ldLink0), .ldLink1(ldLink1), .injValid(injValid),
    .injNode(injNode), .injPort(injPort), .injPtr(injPtr), .injData(injData),
    .injReady(injReady), .readyVec(readyVec), .usedVec(usedVec), .opVec(opVec),
    .resValid(resValid), .resPtr(resPtr), .resData(resData),
    .errValid(errValid), .errCode(errCode)
  );
endmodule

// File: rtl/smdgCheck.sv
module smdgCheck import smdg_pkg::*; (
  input logic clk,
  input logic rstN,
  input logic ldValid,
  input logic [NODE_N-1:0] readyVec,
  input logic [NODE_N-1:0] usedVec,
  input ctl_t ctl,
  input logic resValid,
  input logic errValid,
  input logic [1:0] errCode
);
  AST_FIRE_READY_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |-> readyVec[ctl.node]); // R3
  AST_LOAD_HOLDS_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    ldValid |-> !ctl.fire); // R2
  AST_NO_IDLE_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    ((|readyVec) && !ldValid) |-> ctl.fire); // R10
  AST_ERR_EMITS_NOTHING: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> !resValid); // R12
  AST_POOL_ERR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errCode == ERR_POOL) |-> $past(&usedVec)); // R11
endmodule

bind smdgEngine smdgCheck uChk (
  .clk(clk), .rstN(rstN), .ldValid(ldValid), .readyVec(readyVec),
  .usedVec(usedVec), .ctl(ctl), .resValid(resValid), .errValid(errValid),
  .errCode(errCode)
);

// File: tb/tb_smdgEngine.sv
`timescale 1ns/1ps
module tb_smdgEngine;
  import smdg_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldValid = 1'b0;
  logic [IDX_W-1:0] ldNode = '0;
  logic [2:0] ldOp = '0;
  logic [LINK_W-1:0] ldLink0 = '0, ldLink1 = '0;
  logic injValid = 1'b0;
  logic [IDX_W-1:0] injNode = '0;
  logic injPort = 1'b0, injPtr = 1'b0;
  logic [DATA_W-1:0] injData = '0;
  logic injReady, resValid, resPtr, errValid;
  logic [DATA_W-1:0] resData;
  logic [1:0] errCode;

  int nChecks = 0;
  int nFails = 0;
  logic [DATA_W:0] resQ[$];
  logic [1:0] errQ[$];

  always #10 clk = ~clk;

  smdgEngine dut (.*);

  always @(negedge clk) begin
    if (resValid) resQ.push_back({resPtr, resData});
    if (errValid) errQ.push_back(errCode);
  end

  function automatic logic [LINK_W-1:0] lnk(int node, int port);
    return {1'b1, IDX_W'(node), 1'(port)};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; ldValid = 1'b0; injValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    resQ.delete();
    errQ.delete();
  endtask

  task automatic load(int node, op_e op, logic [LINK_W-1:0] l0, logic [LINK_W-1:0] l1);
    @(negedge clk);
    ldValid = 1'b1; ldNode = IDX_W'(node); ldOp = op; ldLink0 = l0; ldLink1 = l1;
    @(negedge clk);
    ldValid = 1'b0;
  endtask

  task automatic inj(int node, int port, bit ptr, int val);
    @(negedge clk);
    injNode = IDX_W'(node); injPort = 1'(port); injPtr = ptr; injData = DATA_W'(val);
    injValid = 1'b1;
    #1;
    for (int w = 0; w < 200 && !injReady; w++) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    injValid = 1'b0;
  endtask

  task automatic probeReady(int node, int port, output bit r);
    @(negedge clk);
    injNode = IDX_W'(node); injPort = 1'(port);
    #1;
    r = injReady;
  endtask

  task automatic expectRes(bit ptr, int val, string tag);
    logic [DATA_W:0] got;
    for (int w = 0; w < 40 && resQ.size() == 0; w++) @(negedge clk);
    if (resQ.size() == 0) check(1'b0, {tag, " no result"}, -1, val);
    else begin
      got = resQ.pop_front();
      check(got == {ptr, DATA_W'(val)}, tag, int'(got), int'({ptr, DATA_W'(val)}));
    end
  endtask

  task automatic expectNone(int cycles, string tag);
    repeat (cycles) @(negedge clk);
    check(resQ.size() == 0, {tag, " unexpected result"}, resQ.size(), 0);
    resQ.delete();
  endtask

  task automatic expectErr(int code, string tag);
    for (int w = 0; w < 40 && errQ.size() == 0; w++) @(negedge clk);
    if (errQ.size() == 0) check(1'b0, {tag, " no error"}, -1, code);
    else begin
      logic [1:0] c;
      c = errQ.pop_front();
      check(c == 2'(code), tag, c, code);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    bit r;
    doReset();
    // R1 reset state
    #1;
    check(resValid == 1'b0, "R1 resValid", resValid, 0);
    check(errValid == 1'b0, "R1 errValid", errValid, 0);
    probeReady(0, 0, r);
    check(r == 1'b0, "R1 injReady unloaded", r, 0);

    // R10 / R2: round robin, loads hold firing
    for (int n = 0; n < 7; n++) load(n, OP_PASS, '0, '0);
    @(negedge clk);
    ldValid = 1'b1; ldNode = 3'd7; ldOp = OP_PASS; ldLink0 = '0; ldLink1 = '0;
    inj(5, 0, 0, 8'h55); inj(1, 0, 0, 8'h11); inj(3, 0, 0, 8'h33);
    expectNone(4, "R2 load holds firing");
    ldValid = 1'b0;
    expectRes(0, 8'h11, "R10 order first");
    expectRes(0, 8'h33, "R10 order second");
    expectRes(0, 8'h55, "R10 order third");
    @(negedge clk);
    ldValid = 1'b1;
    inj(0, 0, 0, 8'hA0); inj(4, 0, 0, 8'hA4); inj(6, 0, 0, 8'hA6);
    @(negedge clk);
    ldValid = 1'b0;
    expectRes(0, 8'hA6, "R10 wrap first");
    expectRes(0, 8'hA0, "R10 wrap second");
    expectRes(0, 8'hA4, "R10 wrap third");

    // R4 sweep ADD and SUB
    doReset();
    load(0, OP_ADD, '0, '0);
    load(1, OP_SUB, '0, '0);
    for (int x = 0; x < 256; x += 17)
      for (int y = 0; y < 256; y += 23) begin
        inj(0, 0, 0, x); inj(0, 1, 0, y);
        expectRes(0, (x + y) & 8'hFF, "R4 add");
        inj(1, 0, 0, x); inj(1, 1, 0, y);
        expectRes(0, (x - y) & 8'hFF, "R4 sub");
      end

    // R4 fan-out on both edges, PASS keeps tag
    doReset();
    load(0, OP_ADD, lnk(1, 0), lnk(2, 0));
    load(1, OP_PASS, '0, '0);
    load(2, OP_SUB, '0, '0);
    load(3, OP_PASS, '0, '0);
    inj(2, 1, 0, 1);
    inj(0, 0, 0, 40); inj(0, 1, 0, 2);
    expectRes(0, 42, "R4 fanout edge0");
    expectRes(0, 41, "R4 fanout edge1");
    inj(3, 0, 1, 6);
    expectRes(1, 6, "R4 pass keeps pointer tag");

    // R3 operand presence and consumption
    doReset();
    load(0, OP_ADD, '0, '0);
    inj(0, 0, 0, 3);
    expectNone(10, "R3 one operand only");
    inj(0, 1, 0, 4);
    expectRes(0, 7, "R3 both operands");
    inj(0, 0, 0, 6);
    expectNone(10, "R3 operands consumed");
    inj(0, 1, 0, 1);
    expectRes(0, 7, "R3 refill");

    // R5 steer sweep
    doReset();
    load(0, OP_STEER, lnk(1, 0), lnk(2, 0));
    load(1, OP_PASS, '0, '0);
    load(2, OP_ADD, '0, '0);
    for (int ci = 0; ci < 4; ci++)
      for (int d = 0; d < 256; d += 51) begin
        int c;
        c = (ci == 0) ? 0 : (ci == 1) ? 1 : (ci == 2) ? 8'h80 : 8'hFF;
        if (c == 0) inj(2, 1, 0, 100);
        inj(0, 0, 0, d); inj(0, 1, 0, c);
        if (c != 0) expectRes(0, d, "R5 steer true");
        else expectRes(0, (d + 100) & 8'hFF, "R5 steer false");
        expectNone(3, "R5 other edge silent");
      end
    inj(0, 0, 1, 5); inj(0, 1, 0, 1);
    expectRes(1, 5, "R5 steer keeps tag");

    // R6 clone and R8 release
    doReset();
    load(0, OP_CLONE, '0, '0);
    load(1, OP_ADD, '0, '0);
    load(3, OP_RELEASE, '0, '0);
    inj(0, 0, 1, 1);
    expectRes(1, 2, "R6 clone pointer");
    inj(2, 0, 0, 5); inj(2, 1, 0, 7);
    expectRes(0, 12, "R6 clone behaves as source");
    inj(3, 0, 1, 2);
    expectNone(6, "R8 release emits nothing");
    probeReady(2, 0, r);
    check(r == 1'b0, "R8 released node refuses tokens", r, 0);
    inj(0, 0, 1, 1);
    expectRes(1, 2, "R8 released node reallocated");
    inj(0, 0, 0, 1);
    expectErr(1, "R12 clone of data token");

    // R11 empty pool
    doReset();
    load(0, OP_CLONE, '0, '0);
    for (int n = 1; n < 8; n++) load(n, OP_PASS, '0, '0);
    inj(0, 0, 1, 1);
    expectErr(2, "R11 pool empty code");
    expectNone(8, "R11 nothing emitted");
    inj(1, 0, 0, 9);
    expectRes(0, 9, "R11 graph unchanged");

    // R7 redirect
    doReset();
    load(0, OP_PASS, '0, '0);
    load(1, OP_ADD, '0, '0);
    load(2, OP_REDIRECT, '0, '0);
    inj(0, 0, 0, 10);
    expectRes(0, 10, "R7 before redirect");
    inj(2, 0, 1, 0); inj(2, 1, 1, 1);
    expectNone(6, "R7 redirect emits nothing");
    inj(1, 1, 0, 3);
    inj(0, 0, 0, 10);
    expectRes(0, 13, "R7 after redirect");

    // R9 single-token arcs and stall
    doReset();
    load(0, OP_PASS, lnk(1, 0), '0);
    load(1, OP_ADD, '0, '0);
    inj(0, 0, 0, 5);
    inj(0, 0, 0, 9);
    repeat (4) @(negedge clk);
    probeReady(0, 0, r);
    check(r == 1'b0, "R9 stalled producer slot full", r, 0);
    expectNone(2, "R9 no early result");
    inj(1, 1, 0, 20);
    expectRes(0, 25, "R9 first token kept");
    inj(1, 1, 0, 30);
    expectRes(0, 39, "R9 held token delivered");

    // R12 tag errors
    doReset();
    load(0, OP_ADD, '0, '0);
    inj(0, 0, 1, 2); inj(0, 1, 0, 3);
    expectErr(1, "R12 arithmetic on pointer");
    expectNone(6, "R12 nothing emitted");
    inj(0, 0, 0, 1); inj(0, 1, 0, 2);
    expectRes(0, 3, "R12 operands consumed");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule